// File: doc/BRIEF.md
# Octant-Coded Line Rasterizer

This block draws one solid line into a byte-addressed frame buffer. The host loads a start address, a row pitch in bytes, a pixel width of one to four bytes, a command byte carrying the octant, the true major and minor deltas, a signed error seed and a length, and then pulses `start`. The block then emits one byte write per byte of every pixel on a valid/ready interface. Each write carries the byte address and the index of the colour byte that belongs there. It raises `done` for one cycle once the last byte has been accepted.

The command byte packs the octant. Bit 0 set means X runs downward. Bit 1 set means Y runs downward. Bit 2 set makes X the major axis. Bit 4 sets the tie rule. Bits 7:5 must read 3'b101 for the line command. The seed is negated as it is loaded. At each pixel the running term grows by the minor delta. When it turns positive, or reaches zero with the tie bit set, the line takes a minor step and the major delta is subtracted. When X runs downward, the bytes of each pixel are walked from the high byte to the low byte. The colour index follows them, so the colour comes out right at any width.

Top module: `lineRaster`

## Requirements
- R1: After reset `wrValid` and `done` are low, and they stay low until a valid start.
- R2: A start is taken only when `dirCmd[7:5]` is 3'b101 and the block is idle. Any other command value produces no write and no `done`.
- R3: A start pulse while a line is in progress has no effect on the line being drawn.
- R4: With `dirCmd[0]` clear, a pixel at address A is written as `pixBytesM1`+1 bytes at A, A+1, and so on, with `wrByteSel` equal to 0, 1, and so on.
- R5: With `dirCmd[0]` set, the first pixel's address A is moved to `startAddr`+`pixBytesM1`. Its bytes are written at A, A-1, and so on, with `wrByteSel` equal to `pixBytesM1`, `pixBytesM1`-1, and so on.
- R6: An X-major line (`dirCmd[2]`=1) draws `pixCount`+1 pixels. A Y-major line draws `pixCount` pixels, and a Y-major line with `pixCount`=0 draws exactly one pixel and finishes.
- R7: The running term starts at minus `errInit`. After each pixel it adds `minorDelta`. If the result is greater than zero, or equals zero with `dirCmd[4]` set, the next pixel takes a minor step and `majorDelta` is subtracted.
- R8: A step along X moves the address by `pixBytesM1`+1, negative when `dirCmd[0]`=1. A step along Y moves it by `pitch`, negative when `dirCmd[1]`=1. Every pixel takes a major step. Addresses wrap modulo 2^ADDR_W.
- R9: While `wrValid` is high and `wrReady` is low, `wrAddr` and `wrByteSel` hold.
- R10: `done` is high for exactly one cycle, in the cycle after the final byte is accepted, and `wrValid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line with the loaded operands |
| startAddr | input | ADDR_W | Byte address of the first pixel |
| pitch | input | PITCH_W | Bytes per frame-buffer row |
| pixBytesM1 | input | 2 | Bytes per pixel minus one |
| dirCmd | input | 8 | Command and octant byte |
| majorDelta | input | DELTA_W | True major-axis delta |
| minorDelta | input | DELTA_W | True minor-axis delta |
| errInit | input | DELTA_W+1 | Signed error seed, negated on load |
| pixCount | input | DELTA_W | Line length |
| wrValid | output | 1 | Byte write offered |
| wrReady | input | 1 | Byte write accepted |
| wrAddr | output | ADDR_W | Byte address of the write |
| wrByteSel | output | 2 | Colour byte index for the write |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The checker watches the handshake hold (R9), the shape of the `done` pulse (R10) and the range of `wrByteSel` (R4, R5) on every cycle. Which address each byte lands on, the error and tie decisions, the pixel counts per axis and the ignored starts (R2, R3, R6, R7, R8) depend on the whole line. Only the bench can show them, by replaying every octant, pixel width, tie and zero-length case in its model and comparing each accepted write.

// File: rtl/lineRasterPkg.sv
package lineRasterPkg;
  localparam logic [2:0] LINE_OPCODE = 3'b101;

  typedef struct packed {
    logic load;
    logic byteAdv;
    logic pixAdv;
  } lineCtl_t;
endpackage

// File: rtl/lineRasterCtrl.sv
module lineRasterCtrl
  import lineRasterPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic [2:0] opField,
  input  logic     wrReady,
  input  logic     lastByte,
  input  logic     lastPix,
  output lineCtl_t ctl,
  output logic     wrValid,
  output logic     done
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;

  assign wrValid = (state == S_RUN);

  always_comb begin
    ctl = '0;
    if (state == S_IDLE) begin
      ctl.load = start && (opField == LINE_OPCODE);
    end else if (wrReady) begin
      ctl.pixAdv  = lastByte;
      ctl.byteAdv = !lastByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        state <= S_RUN;
      end else if (ctl.pixAdv && lastPix) begin
        state <= S_IDLE;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lineRasterPath.sv
module lineRasterPath
  import lineRasterPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int PITCH_W = 16,
  parameter int DELTA_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  lineCtl_t            ctl,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [PITCH_W-1:0]  pitch,
  input  logic [1:0]          pixBytesM1,
  input  logic [7:0]          dirCmd,
  input  logic [DELTA_W-1:0]  majorDelta,
  input  logic [DELTA_W-1:0]  minorDelta,
  input  logic [DELTA_W:0]    errInit,
  input  logic [DELTA_W-1:0]  pixCount,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [1:0]          wrByteSel,
  output logic                lastByte,
  output logic                lastPix
);
  localparam int EW = DELTA_W + 3;

  logic [ADDR_W-1:0]  pixAddr;
  logic [1:0]         byteIdx, bytesM1;
  logic signed [EW-1:0] errAcc;
  logic [DELTA_W-1:0] remain, majR, minR;
  logic [PITCH_W-1:0] pitchR;
  logic xDec, yDec, xMaj, tieStep;

  // address steps along each axis
  logic [ADDR_W-1:0] bytesA, xStep, yStep, majStep, minStep;
  assign bytesA  = ADDR_W'(bytesM1) + ADDR_W'(1);
  assign xStep   = xDec ? (~bytesA + ADDR_W'(1)) : bytesA;
  assign yStep   = yDec ? (~ADDR_W'(pitchR) + ADDR_W'(1)) : ADDR_W'(pitchR);
  assign majStep = xMaj ? xStep : yStep;
  assign minStep = xMaj ? yStep : xStep;

  // error update for the pixel just finished
  logic signed [EW-1:0] errNext;
  logic stepMinor;
  assign errNext   = errAcc + $signed({3'b000, minR});
  assign stepMinor = (errNext > 0) || ((errNext == 0) && tieStep);

  assign wrAddr    = xDec ? (pixAddr - ADDR_W'(byteIdx)) : (pixAddr + ADDR_W'(byteIdx));
  assign wrByteSel = xDec ? (bytesM1 - byteIdx) : byteIdx;
  assign lastByte  = (byteIdx == bytesM1);
  assign lastPix   = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixAddr <= '0;
      byteIdx <= '0;
      bytesM1 <= '0;
      errAcc  <= '0;
      remain  <= '0;
      majR    <= '0;
      minR    <= '0;
      pitchR  <= '0;
      xDec    <= 1'b0;
      yDec    <= 1'b0;
      xMaj    <= 1'b0;
      tieStep <= 1'b0;
    end else if (ctl.load) begin
      pixAddr <= startAddr + (dirCmd[0] ? ADDR_W'(pixBytesM1) : '0);
      byteIdx <= '0;
      bytesM1 <= pixBytesM1;
      errAcc  <= -$signed({{2{errInit[DELTA_W]}}, errInit});
      remain  <= dirCmd[2] ? pixCount
                           : ((pixCount == '0) ? '0 : pixCount - DELTA_W'(1));
      majR    <= majorDelta;
      minR    <= minorDelta;
      pitchR  <= pitch;
      xDec    <= dirCmd[0];
      yDec    <= dirCmd[1];
      xMaj    <= dirCmd[2];
      tieStep <= dirCmd[4];
    end else if (ctl.pixAdv) begin
      byteIdx <= '0;
      remain  <= remain - DELTA_W'(1);
      errAcc  <= stepMinor ? (errNext - $signed({3'b000, majR})) : errNext;
      pixAddr <= pixAddr + majStep + (stepMinor ? minStep : '0);
    end else if (ctl.byteAdv) begin
      byteIdx <= byteIdx + 2'd1;
    end
  end
endmodule

// File: rtl/lineRaster.sv
module lineRaster
  import lineRasterPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int PITCH_W = 16,
  parameter int DELTA_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [1:0]         pixBytesM1,
  input  logic [7:0]         dirCmd,
  input  logic [DELTA_W-1:0] majorDelta,
  input  logic [DELTA_W-1:0] minorDelta,
  input  logic [DELTA_W:0]   errInit,
  input  logic [DELTA_W-1:0] pixCount,
  output logic               wrValid,
  input  logic               wrReady,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [1:0]         wrByteSel,
  output logic               done
);
  lineCtl_t ctl;
  logic lastByte, lastPix;

  lineRasterCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opField(dirCmd[7:5]),
    .wrReady(wrReady), .lastByte(lastByte), .lastPix(lastPix),
    .ctl(ctl), .wrValid(wrValid), .done(done)
  );

  lineRasterPath #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DELTA_W(DELTA_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr), .pitch(pitch),
    .pixBytesM1(pixBytesM1), .dirCmd(dirCmd), .majorDelta(majorDelta),
    .minorDelta(minorDelta), .errInit(errInit), .pixCount(pixCount),
    .wrAddr(wrAddr), .wrByteSel(wrByteSel), .lastByte(lastByte), .lastPix(lastPix)
  );
endmodule

// File: rtl/lineRasterChecker.sv
module lineRasterChecker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        pixBytesM1,
  input logic              wrValid,
  input logic              wrReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [1:0]        wrByteSel,
  input logic              done
);
  logic [1:0] selMax;
  always_ff @(posedge clk) begin
    if (!rstN) selMax <= 2'd3;
    else if (start && !wrValid) selMax <= pixBytesM1;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrByteSel)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrValid);

  p_sel_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrByteSel <= selMax));
endmodule

bind lineRaster lineRasterChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .pixBytesM1(pixBytesM1),
  .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
  .wrByteSel(wrByteSel), .done(done)
);

// File: tb/test_lineRaster.sv
module test_lineRaster;
  localparam int AW = 24, PW = 16, DW = 12;
  localparam longint AMASK = (64'd1 << AW) - 1;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, wrReady = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [PW-1:0] pitch = '0;
  logic [1:0] pixBytesM1 = '0;
  logic [7:0] dirCmd = '0;
  logic [DW-1:0] majorDelta = '0, minorDelta = '0, pixCount = '0;
  logic [DW:0] errInit = '0;
  logic wrValid, done;
  logic [AW-1:0] wrAddr;
  logic [1:0] wrByteSel;

  always #4 clk = ~clk;

  lineRaster i_lineRaster (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .pitch(pitch),
    .pixBytesM1(pixBytesM1), .dirCmd(dirCmd), .majorDelta(majorDelta),
    .minorDelta(minorDelta), .errInit(errInit), .pixCount(pixCount),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrByteSel(wrByteSel), .done(done)
  );

  int nChecks = 0, nFails = 0, cyc = 0, readyCnt = 0;
  bit stallMode = 0, expDone = 0, running = 0;
  string tag = "R1";
  longint qAddr[$];
  int qSel[$];

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model of one line: fills the expected write queue (R4-R8)
  task automatic model(longint a0, int pit, int bm1, int dir, int maj, int mnr,
                       int e0, int len);
    int npix, err, bytes;
    longint a, xs, ys, mjs, mns;
    bytes = bm1 + 1;
    npix  = dir[2] ? len + 1 : ((len == 0) ? 1 : len);
    err   = -e0;
    xs = dir[0] ? -bytes : bytes;
    ys = dir[1] ? -pit : pit;
    mjs = dir[2] ? xs : ys;
    mns = dir[2] ? ys : xs;
    a = a0 + (dir[0] ? bm1 : 0);
    for (int p = 0; p < npix; p++) begin
      for (int k = 0; k < bytes; k++) begin
        qAddr.push_back((dir[0] ? a - k : a + k) & AMASK);
        qSel.push_back(dir[0] ? bm1 - k : k);
      end
      err = err + mnr;
      if (err > 0 || (err == 0 && dir[4])) begin
        a = a + mns;
        err = err - maj;
      end
      a = (a + mjs) & AMASK;
    end
  endtask

  // cycle-by-cycle comparison against the model queue
  always @(negedge clk) begin
    if (running) begin
      cyc++;
      readyCnt++;
      check(done == expDone, {tag, " R10 done"}, done, expDone);
      expDone = 0;
      wrReady = stallMode ? ((readyCnt % 3) != 0) : 1'b1;
      if (wrValid && qAddr.size() == 0)
        check(0, {tag, " R2/R3 unexpected write"}, wrAddr, 0);
      else if (wrValid && wrReady) begin
        longint ea; int es;
        ea = qAddr.pop_front();
        es = qSel.pop_front();
        check(wrAddr == ea[AW-1:0], {tag, " addr"}, wrAddr, ea);
        check(wrByteSel == es[1:0], {tag, " sel"}, wrByteSel, es);
        if (qAddr.size() == 0) expDone = 1;
      end
      if (cyc > 150000) begin
        check(0, "watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  task automatic runLine(string t, bit stall, longint a0, int pit, int bm1,
                         int dir, int maj, int mnr, int e0, int len);
    @(negedge clk);
    tag = t; stallMode = stall;
    startAddr = a0[AW-1:0]; pitch = pit[PW-1:0]; pixBytesM1 = bm1[1:0];
    dirCmd = dir[7:0]; majorDelta = maj[DW-1:0]; minorDelta = mnr[DW-1:0];
    errInit = e0[DW:0]; pixCount = len[DW-1:0];
    model(a0, pit, bm1, dir, maj, mnr, e0, len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (qAddr.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wrValid == 0, "R1 valid after reset", wrValid, 0);
    check(done == 0, "R1 done after reset", done, 0);
    rstN = 1'b1;
    running = 1;
    repeat (4) @(negedge clk);
    check(wrValid == 0, "R1 idle without start", wrValid, 0);

    // R4 R6 R7: X-major, increasing, one byte
    runLine("R4", 0, 'h1000, 64, 0, 'hA4, 5, 2, 3, 5);
    // R5 R8: X decreasing, Y decreasing, 3-byte pixels, stalls (R9)
    runLine("R5", 1, 'h8000, 100, 2, 'hA7, 4, 3, 2, 4);
    // R6 R8: Y-major, X decreasing, 2-byte pixels
    runLine("R6", 0, 'h4000, 320, 1, 'hA1, 6, 2, 3, 6);
    // R6: Y-major with zero length draws one pixel, 4-byte pixels
    runLine("R6", 1, 'h2000, 40, 3, 'hA0, 0, 0, 0, 0);
    // R7: tie with and without the tie bit
    runLine("R7", 0, 'h3000, 50, 0, 'hB4, 4, 2, 2, 4);
    runLine("R7", 0, 'h3000, 50, 0, 'hA4, 4, 2, 2, 4);
    // R7: negative seed, Y-major, Y decreasing
    runLine("R7", 1, 'h5000, 80, 1, 'hB2, 7, 5, -4, 7);
    // R8: wrap at the top of the address space
    runLine("R8", 0, 'hFFFFFE, 16, 1, 'hA4, 3, 3, 0, 3);

    // R2: non-line command is ignored
    tag = "R2";
    @(negedge clk);
    dirCmd = 8'h24; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check(wrValid == 0, "R2 ignored command valid", wrValid, 0);

    // R3: start while busy does not disturb the line
    @(negedge clk);
    tag = "R3"; stallMode = 1;
    startAddr = 'h6000; pitch = 30; pixBytesM1 = 1; dirCmd = 8'hA4;
    majorDelta = 6; minorDelta = 4; errInit = 1; pixCount = 6;
    model('h6000, 30, 1, 'hA4, 6, 4, 1, 6);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    startAddr = 'h9999; dirCmd = 8'hA3; pixCount = 2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (qAddr.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(wrValid == 0, "R3 no extra line", wrValid, 0);

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule